// File: doc/BRIEF.md
# Serial Display Register Front End

This block is the write side of a four-character dot-matrix LED driver. A host talks to it over a slow three-wire serial link: an active-low enable, a register-select line and a data line that a serial clock strobes in. Each write frame fills one of two shift registers: a 160-bit pixel shift register or an 8-bit command shift register. When the frame ends, the block copies the shifted contents into the registers the rest of the driver reads. These are a 160-bit pixel latch and two 7-bit configuration words. Shifting never disturbs what is shown: the copy happens only once the frame is closed.

The serial pins are sampled by a fast system clock. Edges of the serial clock and the enable are detected in that domain, and no flop is clocked by a pin. The serial output lets several drivers be chained. During pixel frames it presents the bit that falls off the end of the pixel shift register. During command frames it presents either the bit that falls off the command shift register or a direct copy of the serial input. A bit in the second configuration word chooses between the two, so a chain can take one command byte in a single pass.

Top module: `ledser_if`

## Requirements
- R1: The level of `ser_sel_i` seen when `ser_en_n_i` falls picks the frame's destination (0 = pixel shift register, 1 = command shift register). Changes on `ser_sel_i` while the enable stays low have no effect on that frame.
- R2: A rising edge on `ser_clk_i` shifts `ser_data_i` into the selected shift register only while `ser_en_n_i` is low. Rising edges while it is high shift nothing.
- R3: The pixel latch and the configuration words change only after `ser_en_n_i` has returned high and `ser_clk_i` is low. They keep their old values while bits shift and while the serial clock is still held high after the enable rises. The copy happens once per frame.
- R4: Pixel bits shift toward the top index. The k-th bit of a frame (k counted from 0) lands at `dots_o[159-k]` after a full 160-bit frame. During a pixel frame `ser_data_o` equals bit 159 of the pixel shift register.
- R5: Command bytes are sent most significant bit first. Bit 7 of the last eight bits shifted selects the word: 0 loads `ctl0_o`, 1 loads `ctl1_o`. The word takes bits 6..0, and the other word is left as it was.
- R6: Reset clears `ctl0_o`, `ctl1_o` and the command shift register, and leaves `dots_o` and the pixel shift register unchanged.
- R7: During a command frame, `ser_data_o` equals bit 7 of the command shift register when `ctl1_o[0]` is 0. It follows `ser_data_i` combinationally when `ctl1_o[0]` is 1.
- R8: With `ctl1_o[0]` at 1, `ser_data_o` during a pixel frame still carries bit 159 of the pixel shift register and does not follow `ser_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_en_n_i | input | 1 | Active-low frame enable |
| ser_sel_i | input | 1 | Destination select, sampled when the enable falls |
| ser_data_i | input | 1 | Serial data in |
| ser_data_o | output | 1 | Serial data out toward the next driver in a chain |
| ctl0_o | output | 7 | Configuration word 0 |
| ctl1_o | output | 7 | Configuration word 1; bit 0 picks the command pass-through |
| dots_o | output | 160 | Pixel latch |

## Verification
The bench changes `ser_sel_i` in the middle of a frame. A design that sampled the select line continuously would send those bits to the command words. It also holds the serial clock high after closing a frame. An edge-triggered copy would then load the latch early, and an unguarded one would copy again on every later clock pulse. A command frame longer than eight bits checks that only the last byte decides the word and its contents. A wrong shift direction or a wrong select bit shows up as a swapped or corrupted word. The bench also checks that the pass-through tracks the input pin with no clock during command frames but not during pixel frames. Finally it resets the block after loading pixels, which catches a reset wired into the pixel path.

// File: rtl/ledser_pkg.sv
package ledser_pkg;

    localparam int DOT_BITS  = 160;
    localparam int CMD_BITS  = 8;
    localparam int WORD_BITS = CMD_BITS - 1;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        DEST_DOT = 1'b0,
        DEST_CMD = 1'b1
    } dest_e;

    // Synchronized view of the serial pins
    typedef struct packed {
        logic sclk;
        logic en_n;
        logic sel;
        logic data;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, en_n: 1'b1, sel: 1'b0, data: 1'b0};

    // Top bit of a command byte steers it to word 1
    function automatic logic cmd_targets_w1(input logic [CMD_BITS-1:0] b);
        return b[CMD_BITS-1];
    endfunction

    function automatic logic [WORD_BITS-1:0] cmd_payload(input logic [CMD_BITS-1:0] b);
        return b[WORD_BITS-1:0];
    endfunction

endpackage

// File: rtl/ledser_sync.sv
module ledser_sync
    import ledser_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t d,
    output pins_t q
);
    pins_t chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= PINS_IDLE;
                else if (i == 0)
                    chain[i] <= d;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ledser_seq.sv
module ledser_seq
    import ledser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t s,
    output logic  shift,
    output logic  xfer,
    output dest_e dest
);
    pins_t p;
    logic  armed;
    logic  en_fall;
    logic  sclk_rise;

    always_ff @(posedge clk) begin
        if (rst) p <= PINS_IDLE;
        else     p <= s;
    end

    always_comb begin
        en_fall   = p.en_n & ~s.en_n;
        sclk_rise = s.sclk & ~p.sclk;
        shift     = sclk_rise & ~s.en_n;
        xfer      = armed & s.en_n & ~s.sclk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dest  <= DEST_DOT;
            armed <= 1'b0;
        end else begin
            if (en_fall) begin
                dest  <= dest_e'(s.sel);
                armed <= 1'b1;
            end else if (xfer) begin
                armed <= 1'b0;
            end
        end
    end

    // R3: the copy pulse lasts one cycle per frame
    a_r3_single_copy: assert property (@(posedge clk) disable iff (rst)
        xfer |=> !xfer);
endmodule

// File: rtl/ledser_dotpath.sv
module ledser_dotpath
    import ledser_pkg::*;
#(
    parameter int N = DOT_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         xfer,
    input  logic         din,
    output logic [N-1:0] latch,
    output logic         tail
);
    logic [N-1:0] sr;

    // No reset on the pixel storage
    always_ff @(posedge clk) begin
        if (shift) sr <= {sr[N-2:0], din};
        if (xfer)  latch <= sr;
    end

    assign tail = sr[N-1];

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(sr));
    a_r3_latch_only_on_copy: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(latch));
    a_r4_latch_takes_sr: assert property (@(posedge clk) disable iff (rst)
        xfer |=> latch == $past(sr));
endmodule

// File: rtl/ledser_cmdpath.sv
module ledser_cmdpath
    import ledser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift,
    input  logic                 xfer,
    input  logic                 din,
    output logic [WORD_BITS-1:0] w0,
    output logic [WORD_BITS-1:0] w1,
    output logic                 tail
);
    logic [CMD_BITS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
            w0 <= '0;
            w1 <= '0;
        end else begin
            if (shift) sr <= {sr[CMD_BITS-2:0], din};
            if (xfer) begin
                if (cmd_targets_w1(sr)) w1 <= cmd_payload(sr);
                else                    w0 <= cmd_payload(sr);
            end
        end
    end

    assign tail = sr[CMD_BITS-1];

    a_r5_one_word_per_copy: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(w0) || $stable(w1)));
endmodule

// File: rtl/ledser_if.sv
module ledser_if
    import ledser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk_i,
    input  logic                 ser_en_n_i,
    input  logic                 ser_sel_i,
    input  logic                 ser_data_i,
    output logic                 ser_data_o,
    output logic [WORD_BITS-1:0] ctl0_o,
    output logic [WORD_BITS-1:0] ctl1_o,
    output logic [DOT_BITS-1:0]  dots_o
);
    pins_t raw, s;
    logic  shift, xfer;
    dest_e dest;
    logic  dot_tail, cmd_tail;

    assign raw = '{sclk: ser_clk_i, en_n: ser_en_n_i, sel: ser_sel_i, data: ser_data_i};

    ledser_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (s)
    );

    ledser_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .s     (s),
        .shift (shift),
        .xfer  (xfer),
        .dest  (dest)
    );

    ledser_dotpath #(.N(DOT_BITS)) u_dot (
        .clk   (clk),
        .rst   (rst),
        .shift (shift & (dest == DEST_DOT)),
        .xfer  (xfer  & (dest == DEST_DOT)),
        .din   (s.data),
        .latch (dots_o),
        .tail  (dot_tail)
    );

    ledser_cmdpath u_cmd (
        .clk   (clk),
        .rst   (rst),
        .shift (shift & (dest == DEST_CMD)),
        .xfer  (xfer  & (dest == DEST_CMD)),
        .din   (s.data),
        .w0    (ctl0_o),
        .w1    (ctl1_o),
        .tail  (cmd_tail)
    );

    always_comb begin
        if (dest == DEST_CMD)
            ser_data_o = ctl1_o[0] ? ser_data_i : cmd_tail;
        else
            ser_data_o = dot_tail;
    end
endmodule

// File: tb/tb_ledser_if.sv
module tb_ledser_if;
    import ledser_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_en_n = 1'b1, ser_sel = 1'b0, ser_data = 1'b0;
    logic ser_out;
    logic [WORD_BITS-1:0] ctl0, ctl1;
    logic [DOT_BITS-1:0]  dots;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ledser_if dut (
        .clk(clk), .rst(rst),
        .ser_clk_i(ser_clk), .ser_en_n_i(ser_en_n), .ser_sel_i(ser_sel),
        .ser_data_i(ser_data), .ser_data_o(ser_out),
        .ctl0_o(ctl0), .ctl1_o(ctl1), .dots_o(dots)
    );

    // {command byte, expected word 0, expected word 1}
    localparam logic [23:0] VEC [6] = '{
        {8'h4D, 8'h4D, 8'h00},
        {8'h81, 8'h4D, 8'h01},
        {8'h15, 8'h15, 8'h01},
        {8'h80, 8'h15, 8'h00},
        {8'h7F, 8'h7F, 8'h00},
        {8'h82, 8'h7F, 8'h02}
    };

    task automatic chk(input string req, input logic [DOT_BITS-1:0] act, input logic [DOT_BITS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic open_wr(input logic sel);
        ser_sel = sel;
        wait_cyc(3);
        ser_en_n = 1'b0;
        wait_cyc(6);
    endtask

    task automatic push(input logic b);
        ser_data = b;
        ser_clk  = 1'b0;
        wait_cyc(6);
        ser_clk  = 1'b1;
        wait_cyc(6);
    endtask

    task automatic close_hold();
        ser_en_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic release_clk();
        ser_clk = 1'b0;
        wait_cyc(6);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) push(b[i]);
    endtask

    initial begin
        logic [DOT_BITS-1:0] pa, pb, pc;
        pa = {5{32'hA5C3_0F96}};
        pb = {5{32'h3C69_D21E}};
        pc = {pb[DOT_BITS-9:0], 8'h99};

        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        chk("R6 reset word0", DOT_BITS'(ctl0), '0);
        chk("R6 reset word1", DOT_BITS'(ctl1), '0);

        // R5: table of command bytes
        for (int v = 0; v < 6; v++) begin
            open_wr(1'b1);
            send_byte(VEC[v][23:16]);
            close_hold();
            release_clk();
            chk("R5 word0", DOT_BITS'(ctl0), DOT_BITS'(VEC[v][14:8]));
            chk("R5 word1", DOT_BITS'(ctl1), DOT_BITS'(VEC[v][6:0]));
        end

        // R4: full pixel frame
        open_wr(1'b0);
        for (int k = 0; k < DOT_BITS; k++) push(pa[DOT_BITS-1-k]);
        close_hold();
        release_clk();
        chk("R4 latch order", dots, pa);

        // R3/R4: second frame, latch held until copy
        open_wr(1'b0);
        for (int k = 0; k < 20; k++) push(pb[DOT_BITS-1-k]);
        chk("R3 latch during shift", dots, pa);
        chk("R4 chain out", DOT_BITS'(ser_out), DOT_BITS'(pa[DOT_BITS-21]));
        for (int k = 20; k < DOT_BITS; k++) push(pb[DOT_BITS-1-k]);
        chk("R4 chain out full", DOT_BITS'(ser_out), DOT_BITS'(pb[DOT_BITS-1]));
        close_hold();
        chk("R3 latch while clk high", dots, pa);
        release_clk();
        chk("R3 latch after copy", dots, pb);

        // R2: clock edges with enable high shift nothing
        for (int t = 0; t < 5; t++) push(1'b1);
        release_clk();
        open_wr(1'b0);
        close_hold();
        chk("R2 no shift when disabled", dots, pb);
        chk("R2 words unchanged", DOT_BITS'({ctl0, ctl1}), DOT_BITS'({7'h7F, 7'h02}));

        // R1: select changed mid-frame is ignored
        open_wr(1'b0);
        ser_sel = 1'b1;
        send_byte(8'h99);
        close_hold();
        release_clk();
        chk("R1 frame stays on pixels", dots, pc);
        chk("R1 words untouched", DOT_BITS'({ctl0, ctl1}), DOT_BITS'({7'h7F, 7'h02}));

        // R7 serial mode and R5 last byte wins
        open_wr(1'b1);
        send_byte(8'hAA);
        chk("R7 serial out bit7", DOT_BITS'(ser_out), 1);
        push(1'b0);
        chk("R7 serial out next", DOT_BITS'(ser_out), 0);
        close_hold();
        release_clk();
        chk("R5 long frame word0", DOT_BITS'(ctl0), DOT_BITS'(7'h54));
        chk("R5 long frame word1", DOT_BITS'(ctl1), DOT_BITS'(7'h02));

        // R7 pass-through mode
        open_wr(1'b1);
        send_byte(8'h81);
        close_hold();
        release_clk();
        open_wr(1'b1);
        ser_data = 1'b1;
        #1;
        chk("R7 pass-through high", DOT_BITS'(ser_out), 1);
        ser_data = 1'b0;
        #1;
        chk("R7 pass-through low", DOT_BITS'(ser_out), 0);
        wait_cyc(2);
        send_byte(8'h83);
        close_hold();
        release_clk();
        chk("R7 word1 after frame", DOT_BITS'(ctl1), DOT_BITS'(7'h03));

        // R8: pixel frame ignores pass-through
        open_wr(1'b0);
        ser_data = ~pc[DOT_BITS-1];
        wait_cyc(2);
        chk("R8 pixel chain out", DOT_BITS'(ser_out), DOT_BITS'(pc[DOT_BITS-1]));
        close_hold();
        release_clk();
        chk("R8 latch kept", dots, pc);

        // R6: reset spares pixels
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(2);
        chk("R6 word0 cleared", DOT_BITS'(ctl0), '0);
        chk("R6 word1 cleared", DOT_BITS'(ctl1), '0);
        chk("R6 pixels kept", dots, pc);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule